// File: doc/BRIEF.md
# Saturating Fractional Adder with Zero Clamp

This block adds two signed fractions held as 24-bit two's complement values covering [-1, 1). The most significant bit is the sign and the remaining bits are the fraction. A two-bit mode input sets what happens to the sum:

- it wraps around on overflow;
- it saturates to the nearest bound;
- it forces any negative result to zero;
- or it saturates and then zero-clamps.

A condition bit, taken from a control bus outside the block, replaces operand b with zero before the add. A data-dependent choice therefore needs no change in program flow.

The result registers one clock after a valid input. Two flags travel with it. One reports that the exact sum did not fit the format. The other reports that the exact sum was negative. A surrounding datapath places the block after its operand buses. It drives `valid_i` together with the operands and mode, and reads the result one cycle later, qualified by `valid_o`.

Top module: `frac_clamp_adder`

## Requirements
- R1: While `rst_ni` is low, `sum_o`, `ovf_o`, `neg_o` and `valid_o` are all 0.
- R2: `valid_o` equals `valid_i` delayed by one clock. The result for an accepted input appears on the clock edge after `valid_i` is sampled high.
- R3: With `mode_i` = 2'b00, `sum_o` is the low 24 bits of the exact sum of a and the effective b (wrap-around).
- R4: With `mode_i` = 2'b01, a positive overflow gives 24'h7FFFFF and a negative overflow gives 24'h800000. Any other sum passes unchanged.
- R5: With `mode_i` = 2'b10, a wrapped result whose bit 23 is 1 is replaced by 0. For example, 0.5 + 0.7 gives 0, and -0.5 + -0.7 gives the wrapped value +0.8.
- R6: With `mode_i` = 2'b11, saturation is applied first and the zero clamp second. A negative overflow gives 0 and a positive overflow gives 24'h7FFFFF.
- R7: When `cond_i` is 1, operand b is replaced by zero before the add. When `cond_i` is 0, b is used unchanged.
- R8: `ovf_o` is 1 exactly when the exact sum lies outside [-2^23, 2^23-1], whatever the mode. An overflow can only occur when both effective operands have the same sign.
- R9: `neg_o` is 1 exactly when the exact (unwrapped) sum is negative, whatever the mode.
- R10: While `valid_i` is low, `sum_o`, `ovf_o` and `neg_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| a_i | input | 24 | Operand a, signed Q1.23 |
| b_i | input | 24 | Operand b, signed Q1.23 |
| mode_i | input | 2 | 00 wrap, 01 saturate, 10 zero clamp, 11 saturate then zero clamp |
| cond_i | input | 1 | Condition bit from the control bus; 1 zeroes operand b |
| sum_o | output | 24 | Registered result |
| ovf_o | output | 1 | Exact sum out of range |
| neg_o | output | 1 | Exact sum negative |
| valid_o | output | 1 | Result valid |

## Verification
The bench crosses sixteen boundary operands in every mode and both condition values. The operands include both bounds, values one step inside them, ±1 LSB, ±0.5 and ±0.7.

Each target defect shows up at a specific place:
- Overflow detection taken from the wrapped sign alone would raise `ovf_o` on sums such as -1 + 0.5.
- Saturating by the wrapped sign instead of the true sign would send 0.5 + 0.7 to -1.0.
- Applying the clamps in the wrong order would let -0.5 + -0.7 leave combined mode as -1.0 instead of 0.

Hold-while-idle and the one-cycle latency are checked by changing inputs with `valid_i` low.

// File: rtl/frac_add_pkg.sv
package frac_add_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP     = 2'b00,
    MODE_SAT      = 2'b01,
    MODE_ZERO     = 2'b10,
    MODE_SAT_ZERO = 2'b11
  } add_mode_e;
endpackage

// File: rtl/frac_operand_sel.sv
module frac_operand_sel #(
  parameter int W = 24
) (
  input  logic [W-1:0] b_i,
  input  logic         zero_b_i,
  output logic [W-1:0] b_o
);
  assign b_o = zero_b_i ? '0 : b_i;
endmodule

// File: rtl/frac_sum_core.sv
module frac_sum_core #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] wrap_o,
  output logic         ovf_o,
  output logic         neg_o
);
  logic [W:0] ext_sum;

  // one guard bit keeps the exact sign
  assign ext_sum = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign wrap_o  = ext_sum[W-1:0];
  assign ovf_o   = (a_i[W-1] == b_i[W-1]) && (ext_sum[W-1] != a_i[W-1]);
  assign neg_o   = ext_sum[W];
endmodule

// File: rtl/frac_clamp.sv
module frac_clamp
  import frac_add_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] wrap_i,
  input  logic         ovf_i,
  input  logic         neg_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  add_mode_e   mode;
  logic        sat_en, zero_en;
  logic [W-1:0] sat_val;

  always_comb begin
    mode = add_mode_e'(mode_i);
    unique case (mode)
      MODE_WRAP:     begin sat_en = 1'b0; zero_en = 1'b0; end
      MODE_SAT:      begin sat_en = 1'b1; zero_en = 1'b0; end
      MODE_ZERO:     begin sat_en = 1'b0; zero_en = 1'b1; end
      MODE_SAT_ZERO: begin sat_en = 1'b1; zero_en = 1'b1; end
      default:       begin sat_en = 1'b0; zero_en = 1'b0; end
    endcase
  end

  // saturate on true sign, then clamp on resulting sign
  always_comb begin
    sat_val = (sat_en && ovf_i) ? (neg_i ? NEG_MIN : POS_MAX) : wrap_i;
    res_o   = (zero_en && sat_val[W-1]) ? '0 : sat_val;
  end
endmodule

// File: rtl/frac_clamp_adder.sv
module frac_clamp_adder #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   mode_i,
  input  logic         cond_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         neg_o,
  output logic         valid_o
);
  logic [W-1:0] b_eff, wrap_sum, res;
  logic         ovf, neg;

  frac_operand_sel #(.W(W)) u_sel (
    .b_i      (b_i),
    .zero_b_i (cond_i),
    .b_o      (b_eff)
  );

  frac_sum_core #(.W(W)) u_core (
    .a_i    (a_i),
    .b_i    (b_eff),
    .wrap_o (wrap_sum),
    .ovf_o  (ovf),
    .neg_o  (neg)
  );

  frac_clamp #(.W(W)) u_clamp (
    .wrap_i (wrap_sum),
    .ovf_i  (ovf),
    .neg_i  (neg),
    .mode_i (mode_i),
    .res_o  (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      ovf_o   <= 1'b0;
      neg_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o <= res;
        ovf_o <= ovf;
        neg_o <= neg;
      end
    end
  end
endmodule

// File: rtl/frac_clamp_adder_chk.sv
module frac_clamp_adder_chk #(
  parameter int W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         a_msb_i,
  input logic         b_msb_i,
  input logic [1:0]   mode_i,
  input logic         cond_i,
  input logic [W-1:0] sum_o,
  input logic         ovf_o,
  input logic         neg_o,
  input logic         valid_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(sum_o) && $stable(ovf_o) && $stable(neg_o)));

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (cond_i || (a_msb_i != b_msb_i))) |=> !ovf_o);

  // R4
  sat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'b01) |=> (!ovf_o || sum_o == POS_MAX || sum_o == NEG_MIN));

  // R5
  zero_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i[1]) |=> !sum_o[W-1]);

  // R9
  pos_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !a_msb_i && (cond_i || !b_msb_i)) |=> !neg_o);
endmodule

bind frac_clamp_adder frac_clamp_adder_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_msb_i (a_i[W-1]),
  .b_msb_i (b_i[W-1]),
  .mode_i  (mode_i),
  .cond_i  (cond_i),
  .sum_o   (sum_o),
  .ovf_o   (ovf_o),
  .neg_o   (neg_o),
  .valid_o (valid_o)
);

// File: tb/tb_frac_clamp_adder.sv
module tb_frac_clamp_adder;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0]   mode_i = 2'b00;
  logic         cond_i = 1'b0;
  logic [W-1:0] sum_o;
  logic         ovf_o, neg_o, valid_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  frac_clamp_adder #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .mode_i(mode_i), .cond_i(cond_i), .sum_o(sum_o), .ovf_o(ovf_o),
    .neg_o(neg_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] corner(int k);
    case (k)
      0: return 24'h000000;  1: return 24'h000001;
      2: return 24'hFFFFFF;  3: return 24'h7FFFFF;
      4: return 24'h800000;  5: return 24'h7FFFFE;
      6: return 24'h800001;  7: return 24'h400000;
      8: return 24'hC00000;  9: return 24'h3FFFFF;
      10: return 24'hC00001; 11: return 24'h59999A;
      12: return 24'hA66666; 13: return 24'h19999A;
      14: return 24'h000002; default: return 24'h200000;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h mode=%b cond=%b actual=%h expected=%h",
               req, a_i, b_i, mode_i, cond_i, act, exp);
    end
  endtask

  // drive at a falling edge, result sampled at the next falling edge
  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] m, logic c);
    a_i = a; b_i = b; mode_i = m; cond_i = c; valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic model_check();
    longint ts;
    logic [W-1:0] bb, wrap, exp_sum;
    logic exp_ovf, exp_neg;
    string rq;
    bb = cond_i ? '0 : b_i;
    ts = longint'($signed(a_i)) + longint'($signed(bb));
    exp_ovf = (ts > 64'sd8388607) || (ts < -64'sd8388608);
    exp_neg = ts < 0;
    wrap = ts[W-1:0];
    exp_sum = wrap;
    if (mode_i[0] && exp_ovf) exp_sum = exp_neg ? 24'h800000 : 24'h7FFFFF;
    if (mode_i[1] && exp_sum[W-1]) exp_sum = '0;
    case (mode_i)
      2'b00: rq = cond_i ? "R3/R7" : "R3";
      2'b01: rq = cond_i ? "R4/R7" : "R4";
      2'b10: rq = cond_i ? "R5/R7" : "R5";
      default: rq = cond_i ? "R6/R7" : "R6";
    endcase
    check(rq, sum_o, exp_sum);
    check("R8", {23'd0, ovf_o}, {23'd0, exp_ovf});
    check("R9", {23'd0, neg_o}, {23'd0, exp_neg});
    check("R2", {23'd0, valid_o}, 24'd1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R2: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    #1;
    // R1
    check("R1", sum_o, '0);
    check("R1", {21'd0, ovf_o, neg_o, valid_o}, '0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // fixed examples: 0.5+0.7 and -0.5+-0.7
    apply(24'h400000, 24'h59999A, 2'b00, 1'b0); check("R3", sum_o, 24'h99999A);
    apply(24'h400000, 24'h59999A, 2'b01, 1'b0); check("R4", sum_o, 24'h7FFFFF);
    apply(24'h400000, 24'h59999A, 2'b10, 1'b0); check("R5", sum_o, 24'h000000);
    apply(24'h400000, 24'h59999A, 2'b11, 1'b0); check("R6", sum_o, 24'h7FFFFF);
    apply(24'hC00000, 24'hA66666, 2'b01, 1'b0); check("R4", sum_o, 24'h800000);
    apply(24'hC00000, 24'hA66666, 2'b10, 1'b0); check("R5", sum_o, 24'h666666);
    apply(24'hC00000, 24'hA66666, 2'b11, 1'b0); check("R6", sum_o, 24'h000000);
    apply(24'h400000, 24'h59999A, 2'b00, 1'b1); check("R7", sum_o, 24'h400000);

    // R10: idle inputs change, outputs hold
    held = sum_o;
    valid_i = 1'b0; a_i = 24'h123456; b_i = 24'h654321; mode_i = 2'b00;
    @(negedge clk);
    check("R10", sum_o, held);
    check("R2", {23'd0, valid_o}, 24'd0);

    // corner sweep
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int m = 0; m < 4; m++)
          for (int c = 0; c < 2; c++) begin
            apply(corner(i), corner(j), m[1:0], c[0]);
            model_check();
          end

    valid_i = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule